// File: doc/BRIEF.md
# Glitch-Free Clock Stop Controller

This block is the power-management gate of a multi-output clock generator. It takes the generator's internal CPU-rate clock and drives four CPU clock outputs from it. It divides that clock by two to make a PCI-rate clock, and drives six stoppable PCI outputs and one free-running PCI output from the divided clock. Three active-low controls decide what runs: a CPU stop, a PCI stop and a power-down. Each passes through a two-flop synchronizer clocked by the CPU-rate clock. A per-output enable mask can hold any single output low.

Every gate opens or closes only at a clock boundary. A stopped or disabled output therefore never emits a shortened high pulse and always rests low. The CPU gates are captured on the falling edge of the CPU-rate clock and combined with the clock itself. The PCI outputs are registered, and their gates are reloaded only when the divided clock falls. When power-down is requested, the block drains every output to low and then raises a level that tells the oscillator and VCO they may stop. When power-down is released, it drops that level and waits for a programmable startup count before any output runs again. A mode input switches all three controls off, so that everything runs.

Top module: `clk_stop_ctrl`

In the requirements, "the first sampling edge" is the first rising edge of `clk` at which the synchronizer captures a new control level. A CPU output "pulses in cycle k" when it is high during the high phase that follows rising edge k.

## Requirements
- R1: While `rst_n` is low, every clock output and `osc_stop_o` are 0.
- R2: In normal running, each enabled CPU output copies `clk`. The divided PCI clock toggles on every rising edge of `clk`, so it is high on alternate cycles. Every enabled stoppable PCI output is in phase with `pci_free_o`.
- R3: Enable bit i of `cpu_en_i` or `pci_en_i`, or the single bit `pci_free_en_i`, gates the output with the same index: 1 lets it run, 0 holds it low. The bits apply in every mode.
- R4: A CPU output changes only while `clk` is low. No high pulse is ever cut short, and a CPU output is never high while `clk` is low.
- R5: With `mode_i` = 0, take p0 as the first sampling edge of a falling `cpu_stop_n_i`. The CPU outputs still pulse in cycle p0+1 and are low from cycle p0+2. Take p0 as the first sampling edge of a rising `cpu_stop_n_i`. The CPU outputs stay low through cycle p0+4 and pulse again from cycle p0+5, which gives at least three idle cycles after the synchronized release.
- R6: The CPU stop has no effect on any PCI output.
- R7: With `mode_i` = 0, take p0 as the first sampling edge of a falling `pci_stop_n_i`. The stoppable PCI outputs follow R2 through edge p0+2 and are low from edge p0+3. Take p0 as the first sampling edge of a rising `pci_stop_n_i`. They are low through edge p0+2 and follow R2 again from edge p0+3. `pci_free_o` and the CPU outputs are not affected.
- R8: With `mode_i` = 1, all three control inputs are ignored. Every enabled output runs and `osc_stop_o` stays 0.
- R9: With `mode_i` = 0, take p0 as the first sampling edge of a falling `pdown_n_i`. The CPU outputs pulse through cycle p0+2 and are low from cycle p0+3. All PCI outputs are low from edge p0+4. `osc_stop_o` rises at edge p0+5, after every output is already low. While power-down holds, the CPU-stop and PCI-stop inputs have no effect.
- R10: Take p0 as the first sampling edge of a rising `pdown_n_i`, and W as the value of `wake_cnt_i`. `osc_stop_o` falls at edge p0+2. All outputs stay low until the PCI outputs follow R2 again from edge p0+5+W. The CPU outputs pulse again from cycle p0+7+W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal CPU-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 1 | 0 = power-management controls active, 1 = ignore them |
| cpu_stop_n_i | input | 1 | Active-low CPU clock stop |
| pci_stop_n_i | input | 1 | Active-low stop of the stoppable PCI outputs, asynchronous |
| pdown_n_i | input | 1 | Active-low power-down, asynchronous |
| cpu_en_i | input | 4 | Per-output enable of the CPU clocks |
| pci_en_i | input | 6 | Per-output enable of the stoppable PCI clocks |
| pci_free_en_i | input | 1 | Enable of the free-running PCI clock |
| wake_cnt_i | input | 8 | Startup wait after power-down release, in CPU cycles |
| cpu_clk_o | output | 4 | CPU clock outputs |
| pci_clk_o | output | 6 | Stoppable PCI clock outputs |
| pci_free_o | output | 1 | Free-running PCI clock output |
| osc_stop_o | output | 1 | High when the oscillator and VCO may be stopped |

## Verification
The hardest case to reach from the ports is a control change that lands on either phase of the divided clock. One phase closes the PCI gate at once. The other lets one more complete pulse out first. The bench tracks the divided-clock phase from the free-running output and repeats each stop and release at both parities. For every cycle it predicts an exact value, never a window. Power-down release is swept over several startup counts, with the stop inputs toggled while the block is down, to show that the wake timing and the don't-care rule hold together.

// File: rtl/clk_stop_ctrl.sv
module clk_stop_ctrl #(
  parameter int NCPU      = 4,
  parameter int NPCI      = 6,
  parameter int WAKE_W    = 8,
  parameter int SYNC_N    = 2,
  parameter int DRAIN_CYC = 3,
  parameter int CPU_HOLD  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_i,
  input  logic              cpu_stop_n_i,
  input  logic              pci_stop_n_i,
  input  logic              pdown_n_i,
  input  logic [NCPU-1:0]   cpu_en_i,
  input  logic [NPCI-1:0]   pci_en_i,
  input  logic              pci_free_en_i,
  input  logic [WAKE_W-1:0] wake_cnt_i,
  output logic [NCPU-1:0]   cpu_clk_o,
  output logic [NPCI-1:0]   pci_clk_o,
  output logic              pci_free_o,
  output logic              osc_stop_o
);

  localparam int DW     = $clog2(DRAIN_CYC) + 1;
  localparam int CNT_W  = (WAKE_W > DW) ? WAKE_W : DW;
  localparam int HOLD_W = $clog2(CPU_HOLD + 1);

  typedef enum logic [1:0] {ST_RUN, ST_DRAIN, ST_OFF, ST_WAKE} pm_t;

  logic [SYNC_N-1:0] cs_s, ps_s, pd_s;
  pm_t               state;
  logic [CNT_W-1:0]  cnt;
  logic [HOLD_W-1:0] hold;
  logic [NCPU-1:0]   cpu_gate;
  logic              pci_ph;
  logic [NPCI-1:0]   pgate;
  logic              fgate;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_s <= '1;
      ps_s <= '1;
      pd_s <= '1;
    end else begin
      cs_s <= {cs_s[SYNC_N-2:0], cpu_stop_n_i};
      ps_s <= {ps_s[SYNC_N-2:0], pci_stop_n_i};
      pd_s <= {pd_s[SYNC_N-2:0], pdown_n_i};
    end
  end

  wire cs_eff = ~mode_i & ~cs_s[SYNC_N-1];
  wire ps_eff = ~mode_i & ~ps_s[SYNC_N-1];
  wire pd_eff = ~mode_i & ~pd_s[SYNC_N-1];
  wire run    = (state == ST_RUN);
  wire cpu_ok = run & ~cs_eff & (hold == HOLD_W'(CPU_HOLD));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_RUN;
      cnt   <= '0;
    end else begin
      case (state)
        ST_RUN:   if (pd_eff) begin state <= ST_DRAIN; cnt <= '0; end
        ST_DRAIN: if (cnt == CNT_W'(DRAIN_CYC - 1)) begin
                    state <= ST_OFF;
                    cnt   <= '0;
                  end else cnt <= cnt + 1'b1;
        ST_OFF:   if (!pd_eff) begin state <= ST_WAKE; cnt <= '0; end
        default:  if (cnt == CNT_W'(wake_cnt_i)) begin
                    state <= ST_RUN;
                    cnt   <= '0;
                  end else cnt <= cnt + 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                hold <= '0;
    else if (!run || cs_eff)   hold <= '0;
    else if (hold != HOLD_W'(CPU_HOLD)) hold <= hold + 1'b1;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) cpu_gate <= '0;
    else        cpu_gate <= {NCPU{cpu_ok}} & cpu_en_i;
  end

  assign cpu_clk_o = {NCPU{clk}} & cpu_gate;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pci_ph     <= 1'b0;
      pgate      <= '0;
      fgate      <= 1'b0;
      pci_clk_o  <= '0;
      pci_free_o <= 1'b0;
    end else begin
      pci_ph <= ~pci_ph;
      if (pci_ph) begin
        pgate <= {NPCI{run & ~ps_eff}} & pci_en_i;
        fgate <= run & pci_free_en_i;
      end
      pci_clk_o  <= {NPCI{~pci_ph}} & pgate;
      pci_free_o <= ~pci_ph & fgate;
    end
  end

  assign osc_stop_o = (state == ST_OFF);

endmodule

module clk_stop_ctrl_chk #(
  parameter int NCPU = 4,
  parameter int NPCI = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cpu_ok,
  input logic            cs_eff,
  input logic            ps_eff,
  input logic [NCPU-1:0] cpu_gate,
  input logic [NPCI-1:0] pci_clk_o,
  input logic            pci_free_o,
  input logic            pci_free_en_i,
  input logic            osc_stop_o
);

  assert_pci_half_rate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pci_free_o |=> !pci_free_o);

  assert_free_disable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!pci_free_en_i && !$past(pci_free_en_i) && !$past(pci_free_en_i, 2)) |-> !pci_free_o);

  assert_cpu_restart_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_ok) |-> (!$past(cs_eff) && !$past(cs_eff, 2) && !$past(cs_eff, 3)));

  assert_pci_stop_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ps_eff && $past(ps_eff) && $past(ps_eff, 2)) |-> (pci_clk_o == '0));

  assert_off_all_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    osc_stop_o |-> (pci_clk_o == '0 && !pci_free_o && cpu_gate == '0));

endmodule

bind clk_stop_ctrl clk_stop_ctrl_chk #(.NCPU(NCPU), .NPCI(NPCI)) chk_i (
  .clk(clk), .rst_n(rst_n), .cpu_ok(cpu_ok), .cs_eff(cs_eff), .ps_eff(ps_eff),
  .cpu_gate(cpu_gate), .pci_clk_o(pci_clk_o), .pci_free_o(pci_free_o),
  .pci_free_en_i(pci_free_en_i), .osc_stop_o(osc_stop_o)
);

// File: tb/clk_stop_ctrl_tb_top.sv
module clk_stop_ctrl_tb_top;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_i = 1'b0;
  logic       cs_n = 1'b1, ps_n = 1'b1, pd_n = 1'b1;
  logic [3:0] cpu_en = 4'hF;
  logic [5:0] pci_en = 6'h3F;
  logic       free_en = 1'b1;
  logic [7:0] wake = 8'd2;
  logic [3:0] cpu_clk_o;
  logic [5:0] pci_clk_o;
  logic       pci_free_o, osc_stop_o;

  int  n_chk = 0, n_fail = 0, trunc_err = 0;
  bit  ph = 1'b0;
  bit  mon_on = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  clk_stop_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .cpu_stop_n_i(cs_n),
    .pci_stop_n_i(ps_n), .pdown_n_i(pd_n), .cpu_en_i(cpu_en), .pci_en_i(pci_en),
    .pci_free_en_i(free_en), .wake_cnt_i(wake), .cpu_clk_o(cpu_clk_o),
    .pci_clk_o(pci_clk_o), .pci_free_o(pci_free_o), .osc_stop_o(osc_stop_o)
  );

  task automatic tick();
    @(posedge clk);
    #(CLK_P/4);
    ph = ~ph;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] pack(logic osc, logic fr, logic [5:0] p, logic [3:0] c);
    return {osc, fr, p, c};
  endfunction

  task automatic expect_all(input string tag, input logic [3:0] c, input bit pon, input bit fon, input bit osc);
    chk(tag, {20'd0, osc_stop_o, pci_free_o, pci_clk_o, cpu_clk_o},
        {20'd0, pack(osc, fon & ph, (pon & ph) ? 6'h3F : 6'h00, c)});
  endtask

  task automatic summary();
    if (trunc_err != 0 || !mon_on) begin end
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
  endtask

  always begin
    logic [3:0] a, b, l;
    @(posedge clk);
    #(CLK_P/10) a = cpu_clk_o;
    #(CLK_P/5)  b = cpu_clk_o;
    #(CLK_P*2/5) l = cpu_clk_o;
    if (mon_on && (a !== b || l !== 4'h0)) trunc_err++;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R1 reset outputs", {20'd0, osc_stop_o, pci_free_o, pci_clk_o, cpu_clk_o}, 32'd0);
    end
    rst_n = 1'b1;
    mon_on = 1'b1;
    repeat (10) tick();
    ph = pci_free_o;

    for (int i = 0; i < 8; i++) begin
      tick();
      expect_all("R2 free run", 4'hF, 1'b1, 1'b1, 1'b0);
    end

    for (int i = 0; i < 11; i++) begin
      logic [10:0] m;
      m = ~(11'd1 << i);
      cpu_en = m[3:0]; pci_en = m[9:4]; free_en = m[10];
      repeat (4) tick();
      for (int k = 0; k < 6; k++) begin
        tick();
        chk("R3 enable mask", {20'd0, osc_stop_o, pci_free_o, pci_clk_o, cpu_clk_o},
            {20'd0, 1'b0, ph & m[10], ph ? m[9:4] : 6'h00, m[3:0]});
      end
    end
    cpu_en = 4'hF; pci_en = 6'h3F; free_en = 1'b1;
    repeat (4) tick();

    for (int h = 0; h < 4; h++) begin
      cs_n = 1'b0;
      tick(); expect_all("R5 R6 stop before effect", 4'hF, 1'b1, 1'b1, 1'b0);
      tick(); expect_all("R5 R6 last pulse", 4'hF, 1'b1, 1'b1, 1'b0);
      for (int k = 0; k <= h; k++) begin
        tick(); expect_all("R5 R6 cpu stopped", 4'h0, 1'b1, 1'b1, 1'b0);
      end
      cs_n = 1'b1;
      for (int k = 0; k < 5; k++) begin
        tick(); expect_all("R5 R6 restart wait", 4'h0, 1'b1, 1'b1, 1'b0);
      end
      tick(); expect_all("R5 restart pulse", 4'hF, 1'b1, 1'b1, 1'b0);
    end

    for (int p = 0; p < 2; p++) begin
      repeat (p + 1) tick();
      ps_n = 1'b0;
      for (int k = 0; k < 3; k++) begin
        tick(); expect_all("R7 pci before stop", 4'hF, 1'b1, 1'b1, 1'b0);
      end
      for (int k = 0; k < 4; k++) begin
        tick(); expect_all("R7 pci stopped", 4'hF, 1'b0, 1'b1, 1'b0);
      end
      ps_n = 1'b1;
      for (int k = 0; k < 3; k++) begin
        tick(); expect_all("R7 pci release wait", 4'hF, 1'b0, 1'b1, 1'b0);
      end
      for (int k = 0; k < 3; k++) begin
        tick(); expect_all("R7 pci resumed", 4'hF, 1'b1, 1'b1, 1'b0);
      end
    end

    mode_i = 1'b1;
    cs_n = 1'b0; ps_n = 1'b0; pd_n = 1'b0;
    for (int k = 0; k < 10; k++) begin
      tick(); expect_all("R8 mode ignores controls", 4'hF, 1'b1, 1'b1, 1'b0);
    end
    cs_n = 1'b1; ps_n = 1'b1; pd_n = 1'b1;
    repeat (3) tick();
    mode_i = 1'b0;
    repeat (3) tick();

    for (int w = 0; w < 4; w++) begin
      int wv;
      wv = (w == 3) ? 6 : w * w;
      wake = 8'(wv);
      pd_n = 1'b0;
      for (int k = 0; k < 3; k++) begin
        tick(); expect_all("R9 before power-down", 4'hF, 1'b1, 1'b1, 1'b0);
      end
      tick(); expect_all("R9 cpu drained", 4'h0, 1'b1, 1'b1, 1'b0);
      tick(); expect_all("R9 all low", 4'h0, 1'b0, 1'b0, 1'b0);
      tick(); expect_all("R9 osc stop", 4'h0, 1'b0, 1'b0, 1'b1);
      cs_n = 1'b0; ps_n = 1'b0;
      repeat (2) begin tick(); expect_all("R9 stops dont care", 4'h0, 1'b0, 1'b0, 1'b1); end
      cs_n = 1'b1; ps_n = 1'b1;
      repeat (3) begin tick(); expect_all("R9 held down", 4'h0, 1'b0, 1'b0, 1'b1); end
      pd_n = 1'b1;
      repeat (2) begin tick(); expect_all("R10 osc still stopped", 4'h0, 1'b0, 1'b0, 1'b1); end
      for (int k = 0; k < 3 + wv; k++) begin
        tick(); expect_all("R10 wake wait", 4'h0, 1'b0, 1'b0, 1'b0);
      end
      repeat (2) begin tick(); expect_all("R10 pci resumed", 4'h0, 1'b1, 1'b1, 1'b0); end
      repeat (3) begin tick(); expect_all("R10 cpu resumed", 4'hF, 1'b1, 1'b1, 1'b0); end
    end

    chk("R4 no truncated cpu pulse", trunc_err, 0);
    summary();
    $finish;
  end
endmodule